// File: doc/BRIEF.md
# UART Register Front-End

This block sits between a 32-bit memory-mapped bus and a byte-wide serial engine. Software pushes characters by writing a transmit word, pulls a received character by reading a data word, and polls a status word for a receive-full flag and a transmit-ready flag. The block does no bit-level serialization. It holds one received byte in a holding register and hands transmitted bytes to a downstream serializer through a valid/ready pair.

Reading the receive data word empties the holding register. While the register is full, new bytes on the receive side are back-pressured. Writes to the status word are discarded. Only aligned, full-word accesses inside a 24-byte window have any effect. Every other access reads as zero and changes nothing. Read data is registered and appears on the cycle after the request.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the holding register is zero, the receive flag is clear, `rx_ready` is 1, `tx_valid` is 0, and `bus_rdata` is 0.
- R2: A read of byte offset 0x14 returns the status word. Bit 0 is the receive-full flag, bit 1 equals `tx_ready` sampled in the request cycle, and bits 31:2 are zero.
- R3: `rx_ready` is the inverse of the receive-full flag. A cycle with `rx_valid` and `rx_ready` both high loads `rx_data` into the holding register and sets the flag.
- R4: While the flag is set, `rx_ready` is 0 and offered bytes leave the held byte unchanged.
- R5: A read of byte offset 0x04 returns the held byte in bits 7:0 with zeros above, and it clears the receive-full flag. `bus_rdata` is 0 in any cycle that follows a cycle with no valid read.
- R6: If a read of offset 0x04 and an offered byte occur in the same cycle while the flag is set, that byte is not taken in that cycle. It is taken in the following cycle if it is still offered.
- R7: Writes to offset 0x14 change neither the flag nor the held byte.
- R8: A write to offset 0x00 while `tx_ready` is 1 drives `tx_valid` high for exactly one cycle, on the cycle after the write, with `tx_data` equal to `bus_wdata[7:0]`.
- R9: A write to offset 0x00 while `tx_ready` is 0 is dropped, and `tx_valid` stays 0.
- R10: An access is valid only when `bus_be` is all ones, address bits 1:0 are zero, and the address is below 0x18. Invalid accesses and accesses to offsets 0x08, 0x0C and 0x10 read as zero, do not clear the flag, and do not transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window |
| bus_be | input | BUS_W/8 | Byte enables |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | DATA_W | Incoming byte |
| rx_ready | output | 1 | Holding register can accept |
| tx_valid | output | 1 | One-cycle transmit pulse |
| tx_data | output | DATA_W | Byte to transmit |
| tx_ready | input | 1 | Serializer can take a byte |

## Verification
A stuck or wrongly cleared receive-full flag shows at once on `rx_ready`. It also shows one cycle later in bit 0 of a status read. A holding register that is overwritten while full shows on the next data read, as a byte that differs from the first byte offered. Faults in the decode show as nonzero data for invalid reads, or as a `tx_valid` pulse one cycle after a stray write. The collision case needs the flag to be checked on the cycle after a combined read and arrival, and the held byte to be checked after that.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned IDX_TX       = 0;
  localparam int unsigned IDX_RX       = 1;
  localparam int unsigned IDX_ST       = 5;
  localparam int unsigned WINDOW_BYTES = 24;
  localparam int unsigned ST_RXF_BIT   = 0;
  localparam int unsigned ST_TXR_BIT   = 1;

  typedef enum logic [1:0] {RD_NONE, RD_RX, RD_ST} rd_kind_e;

  function automatic int unsigned word_index(input int unsigned byte_addr);
    return byte_addr >> 2;
  endfunction

  function automatic logic [31:0] status_word(input logic rxf, input logic txr);
    logic [31:0] w;
    w = '0;
    w[ST_RXF_BIT] = rxf;
    w[ST_TXR_BIT] = txr;
    return w;
  endfunction
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BE_W   = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output rd_kind_e          rd_kind,
  output logic              tx_wr_hit
);
  logic acc_ok;
  int unsigned idx;

  always_comb begin
    acc_ok    = sel && (be == '1) && (addr[1:0] == 2'b00) &&
                (int'(addr) < int'(WINDOW_BYTES));
    idx       = word_index(int'(addr));
    rd_kind   = RD_NONE;
    tx_wr_hit = 1'b0;
    if (acc_ok) begin
      if (wr) begin
        tx_wr_hit = (idx == IDX_TX);
      end else if (idx == IDX_RX) begin
        rd_kind = RD_RX;
      end else if (idx == IDX_ST) begin
        rd_kind = RD_ST;
      end
    end
  end
endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              rd_clear,
  output logic [DATA_W-1:0] held,
  output logic              full
);
  logic accept;

  assign in_ready = !full;
  assign accept   = in_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      full <= (full && !rd_clear) || accept;
      if (accept) held <= in_data;
    end
  end

  AST_RX_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> full && (held == $past(in_data))); // R3
  AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_clear |=> full && $stable(held)); // R4
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && full |=> !full); // R6
endmodule

// File: rtl/uart_rf_txpush.sv
module uart_rf_txpush #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic push;

  assign push = wr_hit && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= push;
      if (push) out_data <= wdata;
    end
  end

  AST_TX_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(push)); // R8
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !out_ready |=> !out_valid); // R9
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W/8-1:0] bus_be,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_data,
  output logic               rx_ready,
  output logic               tx_valid,
  output logic [DATA_W-1:0]  tx_data,
  input  logic               tx_ready
);
  localparam int BE_W = BUS_W / 8;

  rd_kind_e          rd_kind;
  logic              tx_wr_hit;
  logic              rd_clear;
  logic              rx_full;
  logic [DATA_W-1:0] rx_held;
  logic [BUS_W-1:0]  rd_next;
  logic [31:0]       st_word;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[BUS_W-1:DATA_W];

  uart_rf_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
    .rd_kind(rd_kind), .tx_wr_hit(tx_wr_hit)
  );

  assign rd_clear = (rd_kind == RD_RX);

  uart_rf_rxhold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .in_ready(rx_ready), .rd_clear(rd_clear), .held(rx_held), .full(rx_full)
  );

  uart_rf_txpush #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_hit(tx_wr_hit),
    .wdata(bus_wdata[DATA_W-1:0]), .out_ready(tx_ready),
    .out_valid(tx_valid), .out_data(tx_data)
  );

  assign st_word = status_word(rx_full, tx_ready);

  always_comb begin
    rd_next = '0;
    case (rd_kind)
      RD_RX:   rd_next[DATA_W-1:0] = rx_held;
      RD_ST:   rd_next = BUS_W'(st_word);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && (rd_kind == RD_NONE) |=> bus_rdata == '0); // R10
  AST_ST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kind == RD_ST |=> bus_rdata[ST_TXR_BIT] == $past(tx_ready)); // R2
endmodule

// File: tb/uart_regfront_test.sv
module uart_regfront_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, tx_ready = 1;
  logic [7:0]  tx_data;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  uart_regfront uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = v;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rx_ready", 32'(rx_ready), 1);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(5'h14, 4'hF, d); chk("R1 status", d, 32'h2);
    rd(5'h04, 4'hF, d); chk("R1 held zero", d, 0);
    @(negedge clk); chk("R5 idle rdata zero", bus_rdata, 0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    chk("R3 ready before", 32'(rx_ready), 1);
    offer(8'hA5);
    chk("R3 ready after", 32'(rx_ready), 0);
    rd(5'h14, 4'hF, d); chk("R2 status full", d, 32'h3);
    tx_ready = 0;
    rd(5'h14, 4'hF, d); chk("R2 status txr mirror", d, 32'h1);
    tx_ready = 1;
    rd(5'h04, 4'hF, d); chk("R5 data", d, 32'hA5);
    chk("R5 cleared", 32'(rx_ready), 1);
    rd(5'h14, 4'hF, d); chk("R5 status clear", d, 32'h2);
  endtask

  task automatic t_backpressure;
    logic [31:0] d;
    offer(8'h11);
    offer(8'h22);
    offer(8'h33);
    chk("R4 ready low", 32'(rx_ready), 0);
    rd(5'h04, 4'hF, d); chk("R4 first kept", d, 32'h11);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    offer(8'h5A);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'h04; bus_be = 4'hF;
    rx_valid = 1; rx_data = 8'hC3;
    @(negedge clk);
    bus_sel = 0;
    chk("R6 read old byte", bus_rdata, 32'h5A);
    chk("R6 not taken yet", 32'(rx_ready), 1);
    @(negedge clk);
    rx_valid = 0;
    chk("R6 taken next", 32'(rx_ready), 0);
    rd(5'h04, 4'hF, d); chk("R6 new byte", d, 32'hC3);
  endtask

  task automatic t_status_write;
    logic [31:0] d;
    offer(8'h77);
    wr(5'h14, 4'hF, 32'h0);
    rd(5'h14, 4'hF, d); chk("R7 flag kept", d, 32'h3);
    wr(5'h14, 4'hF, 32'hFFFF_FFFF);
    rd(5'h04, 4'hF, d); chk("R7 byte kept", d, 32'h77);
  endtask

  task automatic t_tx;
    wr(5'h00, 4'hF, 32'h1234_56E7);
    chk("R8 tx_valid", 32'(tx_valid), 1);
    chk("R8 tx_data", 32'(tx_data), 32'hE7);
    @(negedge clk); chk("R8 one cycle", 32'(tx_valid), 0);
    tx_ready = 0;
    wr(5'h00, 4'hF, 32'h99);
    chk("R9 dropped", 32'(tx_valid), 0);
    tx_ready = 1;
    @(negedge clk); chk("R9 still idle", 32'(tx_valid), 0);
  endtask

  task automatic t_bad;
    logic [31:0] d;
    offer(8'h3C);
    rd(5'h04, 4'h7, d); chk("R10 partial be read zero", d, 0);
    rd(5'h05, 4'hF, d); chk("R10 misaligned zero", d, 0);
    rd(5'h08, 4'hF, d); chk("R10 0x08 zero", d, 0);
    rd(5'h10, 4'hF, d); chk("R10 0x10 zero", d, 0);
    rd(5'h18, 4'hF, d); chk("R10 outside zero", d, 0);
    chk("R10 flag kept", 32'(rx_ready), 0);
    wr(5'h00, 4'h1, 32'h55); chk("R10 partial tx none", 32'(tx_valid), 0);
    wr(5'h1C, 4'hF, 32'h55); chk("R10 outside tx none", 32'(tx_valid), 0);
    rd(5'h04, 4'hF, d); chk("R10 byte intact", d, 32'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_backpressure();
    t_collision();
    t_status_write();
    t_tx();
    t_bad();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule